// File: doc/BRIEF.md
# Packed 9-bit Symbol Error Corrector

This block repairs a page buffer after a Reed-Solomon decode pass. The buffer lives in a byte-wide synchronous RAM. Its payload is a stream of 9-bit symbols packed back to back, so most symbols straddle two bytes.

When `start` is pulsed, the block samples a decoder status word and a data-size limit. If the status reports errors that can be fixed, the block fetches the error records one at a time through an indexed read port. Each record names a faulty symbol and carries a 9-bit XOR mask. For every record that points inside the data area, the block reads the two bytes holding that symbol, flips the masked bits and writes both bytes back.

When the pass is over, a single-cycle `done` pulse marks the result outputs as valid. The result is either the number of reported errors or a failure flag. The decoder itself lies outside this block.

Top module: `sym9_corrector`

## Requirements
- R1: When status bit 0 (error present) is clear at start, the block finishes with `res_count` = 0 and `res_fail` = 0, fetches no record and performs no RAM write.
- R2: When status bit 0 is set and status bit 1 (uncorrectable) is set, the block finishes with `res_fail` = 1 and `res_count` = 0, fetches no record and performs no RAM write.
- R3: The number of records is status bits 31:29. Records are fetched in ascending order, index 0 first, each exactly once. The record read port returns data one cycle after `rec_rd`.
- R4: In a record, bits 24:16 hold the symbol position plus one, and bits 8:0 hold the XOR mask. All other record bits have no effect on the buffer.
- R5: A record whose position field is 0, or whose index (position minus 1) is not less than the sampled data size, causes no RAM access.
- R6: For index i, the byte address is i + (i >> 3) and the bit offset is i & 7. Byte [addr] is the low half and byte [addr+1] the high half of a 16-bit word. The mask, shifted left by the offset, is XORed into that word and both bytes are written back.
- R7: On a correctable pass, `res_count` equals status bits 31:29, skipped records included. A count of 0 with the error bit set gives a result of 0 and no fetch.
- R8: `done` is high for exactly one cycle per pass. `data_size` is sampled only in the cycle `start` is accepted, and later changes have no effect on that pass.
- R9: Each applied correction issues RAM cycles in the fixed order: read low byte, read high byte, write low byte, then write high byte at the next address. Reads return data one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a correction pass (accepted when idle) |
| data_size | input | 9 | Number of valid data symbols, sampled at start |
| status | input | 32 | Decoder status word: count in 31:29, uncorrectable in bit 1, error in bit 0 |
| rec_rd | output | 1 | Error record read strobe |
| rec_idx | output | 3 | Index of the record being read |
| rec_data | input | 32 | Record contents, valid one cycle after `rec_rd` |
| ram_addr | output | 10 | Byte address into the page buffer |
| ram_we | output | 1 | Byte write enable |
| ram_wdata | output | 8 | Byte write data |
| ram_rdata | input | 8 | Byte read data, one cycle after the address |
| done | output | 1 | One-cycle end-of-pass pulse |
| res_count | output | 3 | Number of errors reported on success |
| res_fail | output | 1 | Uncorrectable data flag |

## Verification
A wrong byte address or bit offset shows up as a corrupted or untouched buffer byte as soon as the second write of that correction commits. The bench compares the whole buffer after every pass. A stuck record pointer or a wrong loop bound shows up in the order and number of `rec_rd` indices, and in the cycle in which `done` appears. A bad status decode shows up at the `done` pulse as a wrong count or fail flag, or as RAM writes during a pass that should leave the buffer alone. Sampling the size limit at the wrong time changes which boundary records are applied, and this is visible in the buffer after that pass.

// File: rtl/sym9_pkg.sv
package sym9_pkg;
  // Symbol and record field geometry
  localparam int SYM_W    = 9;
  localparam int POS_W    = 9;
  localparam int POS_LSB  = 16;
  localparam int MASK_LSB = 0;
  localparam int CNT_W    = 3;
  localparam int CNT_LSB  = 29;
  localparam int ERR_BIT  = 0;
  localparam int UNC_BIT  = 1;
  localparam int OFF_W    = 3;
  localparam int PAT_W    = SYM_W + (1 << OFF_W) - 1;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_LOOK, S_RDLO, S_RDHI, S_WRLO, S_WRHI, S_NEXT, S_FIN
  } fix_state_t;
endpackage

// File: rtl/sym9_locate.sv
module sym9_locate
  import sym9_pkg::*;
#(
  parameter int REC_W = 32,
  parameter int AW    = POS_W + 1
) (
  input  logic [REC_W-1:0] rec,
  input  logic [POS_W-1:0] limit,
  output logic             hit,
  output logic [AW-1:0]    addr,
  output logic [OFF_W-1:0] off,
  output logic [SYM_W-1:0] mask
);
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] idx;
  logic             unused_rec;

  assign pos  = rec[POS_LSB +: POS_W];
  assign mask = rec[MASK_LSB +: SYM_W];
  assign idx  = pos - POS_W'(1);
  // position 0 encodes "no symbol"; anything at or past the limit is skipped
  assign hit  = (pos != '0) && (idx < limit);
  // eight 9-bit symbols fill nine bytes
  assign addr = AW'(idx) + AW'(idx >> OFF_W);
  assign off  = idx[OFF_W-1:0];

  assign unused_rec = ^{rec[REC_W-1:POS_LSB+POS_W], rec[POS_LSB-1:MASK_LSB+SYM_W]};
endmodule

// File: rtl/sym9_pattern.sv
module sym9_pattern
  import sym9_pkg::*;
(
  input  logic [SYM_W-1:0] mask,
  input  logic [OFF_W-1:0] off,
  output logic [PAT_W-1:0] pat
);
  // barrel shift, one stage per offset bit
  logic [PAT_W-1:0] stage [OFF_W+1];

  assign stage[0] = PAT_W'(mask);
  for (genvar b = 0; b < OFF_W; b++) begin : g_shift
    assign stage[b+1] = off[b] ? (stage[b] << (1 << b)) : stage[b];
  end
  assign pat = stage[OFF_W];
endmodule

// File: rtl/sym9_corrector.sv
module sym9_corrector
  import sym9_pkg::*;
#(
  parameter int REC_W  = 32,
  parameter int BYTE_W = 8,
  localparam int AW    = POS_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [POS_W-1:0]  data_size,
  input  logic [REC_W-1:0]  status,
  output logic              rec_rd,
  output logic [CNT_W-1:0]  rec_idx,
  input  logic [REC_W-1:0]  rec_data,
  output logic [AW-1:0]     ram_addr,
  output logic              ram_we,
  output logic [BYTE_W-1:0] ram_wdata,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic              done,
  output logic [CNT_W-1:0]  res_count,
  output logic              res_fail
);
  fix_state_t        st;
  logic [POS_W-1:0]  size_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  ptr_q;
  logic              err_q;
  logic              unc_q;
  logic [AW-1:0]     addr_q;
  logic [PAT_W-1:0]  pat_q;
  logic [BYTE_W-1:0] lo_q;
  logic [BYTE_W-1:0] hi_q;
  logic              done_q;

  logic              loc_hit;
  logic [AW-1:0]     loc_addr;
  logic [OFF_W-1:0]  loc_off;
  logic [SYM_W-1:0]  loc_mask;
  logic [PAT_W-1:0]  loc_pat;
  logic [CNT_W-1:0]  st_cnt;
  logic              unused_status;

  assign st_cnt        = status[CNT_LSB +: CNT_W];
  assign unused_status = ^status[CNT_LSB-1:UNC_BIT+1];

  sym9_locate #(.REC_W(REC_W), .AW(AW)) u_locate (
    .rec   (rec_data),
    .limit (size_q),
    .hit   (loc_hit),
    .addr  (loc_addr),
    .off   (loc_off),
    .mask  (loc_mask)
  );

  sym9_pattern u_pattern (
    .mask (loc_mask),
    .off  (loc_off),
    .pat  (loc_pat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      size_q    <= '0;
      cnt_q     <= '0;
      ptr_q     <= '0;
      err_q     <= 1'b0;
      unc_q     <= 1'b0;
      addr_q    <= '0;
      pat_q     <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      done_q    <= 1'b0;
      res_count <= '0;
      res_fail  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            size_q <= data_size;
            cnt_q  <= st_cnt;
            err_q  <= status[ERR_BIT];
            unc_q  <= status[ERR_BIT] & status[UNC_BIT];
            ptr_q  <= '0;
            if (!status[ERR_BIT]) begin
              res_count <= '0;
              res_fail  <= 1'b0;
              st        <= S_FIN;
            end else if (status[UNC_BIT]) begin
              res_count <= '0;
              res_fail  <= 1'b1;
              st        <= S_FIN;
            end else if (st_cnt == '0) begin
              res_count <= '0;
              res_fail  <= 1'b0;
              st        <= S_FIN;
            end else begin
              st <= S_FETCH;
            end
          end
        end
        S_FETCH: st <= S_LOOK;
        S_LOOK: begin
          if (loc_hit) begin
            addr_q <= loc_addr;
            pat_q  <= loc_pat;
            st     <= S_RDLO;
          end else begin
            st <= S_NEXT;
          end
        end
        S_RDLO: st <= S_RDHI;
        S_RDHI: begin
          lo_q <= ram_rdata;
          st   <= S_WRLO;
        end
        S_WRLO: begin
          hi_q <= ram_rdata;
          st   <= S_WRHI;
        end
        S_WRHI: st <= S_NEXT;
        S_NEXT: begin
          if (ptr_q == cnt_q - CNT_W'(1)) begin
            res_count <= cnt_q;
            res_fail  <= 1'b0;
            st        <= S_FIN;
          end else begin
            ptr_q <= ptr_q + CNT_W'(1);
            st    <= S_FETCH;
          end
        end
        S_FIN: begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // outputs decode straight from state and data flops
  assign rec_rd  = (st == S_FETCH);
  assign rec_idx = ptr_q;
  assign done    = done_q;
  assign ram_we  = (st == S_WRLO) || (st == S_WRHI);

  always_comb begin
    ram_addr  = addr_q;
    ram_wdata = lo_q ^ pat_q[BYTE_W-1:0];
    if (st == S_RDHI || st == S_WRHI) begin
      ram_addr = addr_q + AW'(1);
    end
    if (st == S_WRHI) begin
      ram_wdata = hi_q ^ pat_q[PAT_W-1:BYTE_W];
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  wr_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_we && !$past(ram_we)) |=> (ram_we && ram_addr == $past(ram_addr) + AW'(1)));

  // R2
  no_write_on_fail_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !unc_q);

  // R3
  rec_idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rec_rd |-> (rec_idx < cnt_q));

  // R5
  write_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_addr <= AW'(size_q) + AW'(size_q >> OFF_W)));

  // R1
  clean_result_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !err_q) |-> (res_count == '0 && !res_fail));
endmodule

// File: tb/sym9_corrector_test.sv
module sym9_corrector_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [8:0]  data_size = '0;
  logic [31:0] status = '0;
  logic        rec_rd;
  logic [2:0]  rec_idx;
  logic [31:0] rec_data = '0;
  logic [9:0]  ram_addr;
  logic        ram_we;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;
  logic        done;
  logic [2:0]  res_count;
  logic        res_fail;

  always #(CLK_PERIOD/2) clk = ~clk;

  sym9_corrector uut (
    .clk(clk), .rst(rst), .start(start), .data_size(data_size), .status(status),
    .rec_rd(rec_rd), .rec_idx(rec_idx), .rec_data(rec_data),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .done(done), .res_count(res_count), .res_fail(res_fail)
  );

  logic [7:0]  mem     [MEM_BYTES];
  logic [7:0]  exp_mem [MEM_BYTES];
  logic [31:0] recs    [8];
  int          wr_cnt;
  int          fetch_n;
  int          fetch_log [16];
  int          n_checks = 0;
  int          n_fail = 0;
  bit          prev_done = 1'b0;

  typedef struct {
    int    cnt;
    bit    fail;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  // buffer and record port models, one cycle read latency each
  always @(posedge clk) begin
    ram_rdata <= mem[ram_addr];
    if (ram_we) begin
      mem[ram_addr] = ram_wdata;
      wr_cnt = wr_cnt + 1;
    end
    if (rec_rd) begin
      rec_data <= recs[rec_idx];
      if (fetch_n < 16) fetch_log[fetch_n] = int'(rec_idx);
      fetch_n = fetch_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor: pops expected results on each done pulse
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(int'(res_count) == e.cnt, e.tag, "res_count", int'(res_count), e.cnt);
          chk(res_fail == e.fail, e.tag, "res_fail", int'(res_fail), int'(e.fail));
        end
      end
      if (prev_done && done) chk(1'b0, "R8", "done longer than one cycle", 2, 1);
      prev_done = done;
    end
  end

  function automatic logic [31:0] mkrec(input int pos, input int mask, input int junk);
    logic [31:0] r;
    r = 32'(junk);
    r[24:16] = 9'(pos);
    r[8:0]   = 9'(mask);
    return r;
  endfunction

  // driver: computes the expected buffer and result, then runs one pass
  task automatic run(input logic [31:0] st, input int sz, input int sz_late,
                     input int seed, input string tag);
    int   cnt;
    int   hits;
    int   k;
    int   bad;
    int   exp_fetch;
    exp_t e;
    for (int i = 0; i < MEM_BYTES; i++) begin
      mem[i]     = 8'((i * 37 + seed) & 255);
      exp_mem[i] = mem[i];
    end
    cnt  = int'(st[31:29]);
    hits = 0;
    if (st[0] && !st[1]) begin
      for (int i = 0; i < cnt; i++) begin
        int pos;
        int idx;
        int a;
        logic [15:0] w;
        pos = int'(recs[i][24:16]);
        idx = pos - 1;
        if (pos != 0 && idx < sz) begin
          a = idx + (idx >> 3);
          w = {exp_mem[a+1], exp_mem[a]};
          w = w ^ (16'(recs[i][8:0]) << (idx & 7));
          exp_mem[a]   = w[7:0];
          exp_mem[a+1] = w[15:8];
          hits++;
        end
      end
    end
    e.tag  = tag;
    e.fail = !(st[0] == 1'b0) && st[1];
    e.cnt  = (st[0] && !st[1]) ? cnt : 0;
    exp_fetch = (st[0] && !st[1]) ? cnt : 0;
    sb_q.push_back(e);
    wr_cnt  = 0;
    fetch_n = 0;
    @(negedge clk);
    status    = st;
    data_size = 9'(sz);
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
    data_size = 9'(sz_late);
    k = 0;
    while (!done && k < 2000) begin
      @(negedge clk);
      k++;
    end
    if (k >= 2000) chk(1'b0, tag, "pass timed out", k, 0);
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < MEM_BYTES; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(bad == 0, tag, "buffer bytes differing", bad, 0);
    chk(wr_cnt == 2 * hits, tag, "ram writes", wr_cnt, 2 * hits);
    chk(fetch_n == exp_fetch, tag, "records fetched", fetch_n, exp_fetch);
    for (int i = 0; i < fetch_n && i < 16; i++)
      chk(fetch_log[i] == i, "R3", "fetch order", fetch_log[i], i);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) recs[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(done == 1'b0, "R8", "done after reset", int'(done), 0);
    chk(ram_we == 1'b0, "R8", "ram_we after reset", int'(ram_we), 0);
    chk(rec_rd == 1'b0, "R8", "rec_rd after reset", int'(rec_rd), 0);
    chk(res_fail == 1'b0, "R8", "res_fail after reset", int'(res_fail), 0);

    // R1: error bit clear, records present but ignored
    for (int i = 0; i < 8; i++) recs[i] = mkrec(i * 3 + 1, 9'h1ff, 0);
    run(32'hE000_0000, 100, 100, 5, "R1");

    // R2: uncorrectable
    run(32'h6000_0003, 100, 100, 9, "R2");

    // R6 and R4: offsets 0, 7 and 4, junk in unused record bits
    recs[0] = mkrec(1, 9'h1ff, 32'hFE00_FE00);
    recs[1] = mkrec(8, 9'h155, 32'h0000_AA00);
    recs[2] = mkrec(21, 9'h0ab, 32'h8000_0200);
    run(32'h6000_0001, 100, 100, 11, "R6");

    // R5 and R7: position 0, index at limit, index just below limit
    recs[0] = mkrec(0, 9'h1ff, 0);
    recs[1] = mkrec(101, 9'h1ff, 0);
    recs[2] = mkrec(100, 9'h0f3, 0);
    recs[3] = mkrec(9, 9'h101, 0);
    run(32'h8000_0001, 100, 100, 17, "R5");

    // R3, R9: seven records, shared bytes, repeated symbol, top index
    recs[0] = mkrec(9, 9'h1ff, 0);
    recs[1] = mkrec(10, 9'h0f0, 0);
    recs[2] = mkrec(11, 9'h00f, 0);
    recs[3] = mkrec(40, 9'h123, 0);
    recs[4] = mkrec(40, 9'h123, 0);
    recs[5] = mkrec(511, 9'h1a5, 0);
    recs[6] = mkrec(16, 9'h111, 0);
    run(32'hE000_0001, 511, 511, 23, "R3");

    // R8: size sampled at start, later change ignored
    recs[0] = mkrec(50, 9'h0ff, 0);
    recs[1] = mkrec(51, 9'h1ff, 0);
    run(32'h4000_0001, 50, 511, 29, "R8");

    // R7: error bit set with zero records
    run(32'h0000_0001, 100, 100, 31, "R7");

    // R9: back-to-back single correction at the last byte pair of a group
    recs[0] = mkrec(16, 9'h1c3, 0);
    run(32'h2000_0001, 20, 20, 41, "R9");

    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R8", "results still pending", sb_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule